// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Holding Latches

This block turns a slow serial stream into a parallel word. A shift clock, a strobe, a serial data bit and an output enable come from outside the chip's clock domain. The block samples all four on the system clock and finds the rising and falling edges of the shift clock from those samples. On each rising shift edge the register moves one place toward its last stage, and the new bit enters the first stage.

Behind every stage sits a holding latch. While the strobe is high the latch is transparent, so the parallel outputs follow the register. When the strobe is low the latch keeps its value, so the outputs stay frozen while a new word is shifted in. The output enable drives a per-bit drive-enable vector, which stands in for a three-state driver. It has no effect on shifting or latching.

Two serial outputs feed the next device in a chain. The fast one always shows the last stage. The slow one picks up that value on the falling shift edge, half a shift period later, so that a slow downstream device has more hold margin.

Top module: `strobed_shift_latch`

## Requirements
- R1: On a detected rising shift edge, stage 1 loads the synchronized serial bit and each other stage k loads stage k-1. `par_data[0]` shows stage 1 and `par_data[STAGES-1]` shows the last stage. After eight shifts, the first bit sent therefore appears on bit 7.
- R2: After every rising shift edge, `ser_fast` equals the last stage, which is the value that stage 7 held before the edge.
- R3: `ser_slow` changes only on a detected falling shift edge. At that edge it loads the value `ser_fast` had during the preceding high phase, so it lags `ser_fast` by exactly one falling edge.
- R4: While the synchronized strobe is high, `par_data` equals the register contents. After the strobe falls, `par_data` holds the contents the register had on the last cycle the strobe was high.
- R5: Shifting while the strobe is low leaves `par_data` unchanged.
- R6: While the synchronized enable is low, every bit of `par_en` is 0, and while it is high every bit is 1. The serial outputs are never gated.
- R7: With the enable low, shifting and latching go on as normal, and `par_data` still reports the latched word.
- R8: Each raw input passes two synchronizer flops. A rising transition of `sclk_in` changes the register state after the third rising system-clock edge that follows it, not before. The serial bit is taken from its synchronized value at that time, so it must be stable two system cycles before the shift clock rises.
- R9: A synchronous active-high `rst` clears the synchronizers, every stage, every latch and both serial outputs to 0. During reset `par_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous shift clock |
| strobe_in | input | 1 | Asynchronous latch strobe, transparent when high |
| data_in | input | 1 | Asynchronous serial data |
| oe_in | input | 1 | Asynchronous output enable |
| par_data | output | STAGES | Latched parallel word, bit 0 is stage 1 |
| par_en | output | STAGES | Per-bit drive enable |
| ser_fast | output | 1 | Last stage, updates on rising shift edges |
| ser_slow | output | 1 | Last stage repeated on falling shift edges |

## Verification
The bench shifts a whole word in while the strobe is low. A latch that passed data through regardless of the strobe would show the partial word. It then lowers the strobe after a full word and shifts again, which catches a design whose latches never hold. It counts system edges after a shift clock rise, so a synchronizer that is a stage short or long shows up as an early or late change. It picks a bit pattern in which the last stage flips, so a slow output that updated on the rising edge would match the fast one too soon. Finally, it shifts with the enable low, which catches enable logic that also froze the register or masked the data.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    // Raw and synchronized control/data sample
    typedef struct packed {
        logic sclk;
        logic strobe;
        logic data;
        logic oe;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Edge indication of the shift clock
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t find_edge(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync
    import sreg_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  raw_i,
    output ctl_t  sync_o,
    output edge_t sclk_edge_o
);
    localparam int PIPE_W = SYNC_DEPTH * CTL_W;

    logic [PIPE_W-1:0] pipe_q;
    logic              sclk_prev_q;

    generate
        if (SYNC_DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= raw_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[PIPE_W-CTL_W-1:0], raw_i};
            end
        end
    endgenerate

    assign sync_o = ctl_t'(pipe_q[PIPE_W-1 -: CTL_W]);

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sync_o.sclk;
    end

    assign sclk_edge_o = find_edge(sync_o.sclk, sclk_prev_q);

endmodule

// File: rtl/sreg_chain.sv
module sreg_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              fall_i,
    input  logic              din_i,
    output logic [STAGES-1:0] stage_o,
    output logic              fast_o,
    output logic              slow_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;
    logic              slow_q;

    always_ff @(posedge clk) begin
        if (rst)          stage_q <= '0;
        else if (shift_i) stage_q <= {stage_q[LAST-1:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (rst)         slow_q <= 1'b0;
        else if (fall_i) slow_q <= stage_q[LAST];
    end

    assign stage_o = stage_q;
    assign fast_o  = stage_q[LAST];
    assign slow_o  = slow_q;

endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic              oe_i,
    input  logic [STAGES-1:0] stage_i,
    output logic [STAGES-1:0] par_data_o,
    output logic [STAGES-1:0] par_en_o
);
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_bit
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst)           held_q <= 1'b0;
                else if (strobe_i) held_q <= stage_i[i];
            end
            assign par_data_o[i] = strobe_i ? stage_i[i] : held_q;
            assign par_en_o[i]   = oe_i;
        end
    endgenerate

endmodule

// File: rtl/strobed_shift_latch.sv
module strobed_shift_latch
    import sreg_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              strobe_in,
    input  logic              data_in,
    input  logic              oe_in,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_en,
    output logic              ser_fast,
    output logic              ser_slow
);
    ctl_t              raw_w;
    ctl_t              sync_w;
    edge_t             edge_w;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              strobe_s;
    logic              oe_s;
    logic              data_s;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        raw_w.sclk   = sclk_in;
        raw_w.strobe = strobe_in;
        raw_w.data   = data_in;
        raw_w.oe     = oe_in;
    end

    sreg_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .raw_i       (raw_w),
        .sync_o      (sync_w),
        .sclk_edge_o (edge_w)
    );

    assign sclk_rise = edge_w.rise;
    assign sclk_fall = edge_w.fall;
    assign strobe_s  = sync_w.strobe;
    assign oe_s      = sync_w.oe;
    assign data_s    = sync_w.data;

    sreg_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift_i (sclk_rise),
        .fall_i  (sclk_fall),
        .din_i   (data_s),
        .stage_o (stage_q),
        .fast_o  (ser_fast),
        .slow_o  (ser_slow)
    );

    sreg_store #(.STAGES(STAGES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .strobe_i   (strobe_s),
        .oe_i       (oe_s),
        .stage_i    (stage_q),
        .par_data_o (par_data),
        .par_en_o   (par_en)
    );

endmodule

// File: rtl/strobed_shift_latch_chk.sv
module strobed_shift_latch_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              strobe_s,
    input logic              data_s,
    input logic [STAGES-1:0] stage_q,
    input logic [STAGES-1:0] par_data,
    input logic [STAGES-1:0] par_en,
    input logic              ser_fast,
    input logic              ser_slow
);
    a_r1_shift_moves: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> stage_q == {$past(stage_q[STAGES-2:0]), $past(data_s)});

    a_r2_fast_takes_stage7: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> ser_fast == $past(stage_q[STAGES-2]));

    a_r3_slow_quiet: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(ser_slow));

    a_r3_slow_loads_fast: assert property (@(posedge clk) disable iff (rst)
        sclk_fall |=> ser_slow == $past(ser_fast));

    a_r4_transparent: assert property (@(posedge clk) disable iff (rst)
        strobe_s |-> par_data == stage_q);

    a_r5_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (!strobe_s && !$past(strobe_s)) |-> $stable(par_data));

    a_r6_enable_uniform: assert property (@(posedge clk) disable iff (rst)
        ($countones(par_en) == 0) || ($countones(par_en) == STAGES));

endmodule

bind strobed_shift_latch strobed_shift_latch_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .strobe_s  (strobe_s),
    .data_s    (data_s),
    .stage_q   (stage_q),
    .par_data  (par_data),
    .par_en    (par_en),
    .ser_fast  (ser_fast),
    .ser_slow  (ser_slow)
);

// File: tb/strobed_shift_latch_tb_top.sv
`timescale 1ns/1ps
module strobed_shift_latch_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_in = 1'b0;
    logic         strobe_in = 1'b0;
    logic         data_in = 1'b0;
    logic         oe_in = 1'b0;
    logic [N-1:0] par_data;
    logic [N-1:0] par_en;
    logic         ser_fast;
    logic         ser_slow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    strobed_shift_latch #(.STAGES(N), .SYNC_DEPTH(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk_in),
        .strobe_in (strobe_in),
        .data_in   (data_in),
        .oe_in     (oe_in),
        .par_data  (par_data),
        .par_en    (par_en),
        .ser_fast  (ser_fast),
        .ser_slow  (ser_slow)
    );

    // Behavioural reference: history of raw samples, newest first
    bit [3:0] hist[$];          // {sclk, strobe, data, oe}
    bit [N-1:0] m_reg, m_held;
    bit m_slow, m_strobe_vis, m_oe_vis;
    bit model_ok = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            hist = {4'b0, 4'b0, 4'b0};
            m_reg = '0; m_held = '0; m_slow = 1'b0;
            m_strobe_vis = 1'b0; m_oe_vis = 1'b0;
            model_ok = 1'b1;
        end else begin
            bit [3:0] cur2, cur3, cur1;
            cur1 = hist[0]; cur2 = hist[1]; cur3 = hist[2];
            if (cur2[2]) m_held = m_reg;
            if (!cur2[3] && cur3[3]) m_slow = m_reg[N-1];
            if (cur2[3] && !cur3[3]) m_reg = {m_reg[N-2:0], cur2[1]};
            m_strobe_vis = cur1[2];
            m_oe_vis = cur1[0];
            hist.push_front({sclk_in, strobe_in, data_in, oe_in});
            while (hist.size() > 3) void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && model_ok && !done) begin
            check("R4 par_data vs model", par_data, m_strobe_vis ? m_reg : m_held);
            check("R6 par_en vs model", par_en, m_oe_vis ? '1 : '0);
            check("R2 ser_fast vs model", {7'b0, ser_fast}, {7'b0, m_reg[N-1]});
            check("R3 ser_slow vs model", {7'b0, ser_slow}, {7'b0, m_slow});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise_phase(input bit b);
        data_in = b;
        tick(3);
        sclk_in = 1'b1;
        tick(4);
    endtask

    task automatic fall_phase();
        sclk_in = 1'b0;
        tick(4);
    endtask

    task automatic shift_byte(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) begin
            rise_phase(v[i]);
            fall_phase();
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] exp_b;
        logic f0;
        tick(4);
        // R9: reset state
        check("R9 reset par_data", par_data, '0);
        check("R9 reset par_en", par_en, '0);
        check("R9 reset serial", {6'b0, ser_fast, ser_slow}, '0);
        @(negedge clk); rst = 1'b0;
        oe_in = 1'b1;
        tick(4);
        check("R6 enable high", par_en, '1);

        // R5: load with strobe low, outputs stay at 0
        exp_b = 8'hB4;
        shift_byte(exp_b);
        check("R5 no change with strobe low", par_data, 8'h00);

        // R1, R4: strobe high shows the word, bit 0 = stage 1
        strobe_in = 1'b1;
        tick(3);
        check("R1 R4 word appears", par_data, exp_b);
        check("R2 fast is last stage", {7'b0, ser_fast}, {7'b0, exp_b[7]});

        // R3: slow lags fast by one falling edge
        f0 = ser_fast;
        rise_phase(1'b1);
        exp_b = {exp_b[6:0], 1'b1};
        check("R3 slow unchanged on rise", {7'b0, ser_slow}, {7'b0, f0});
        check("R2 fast after rise", {7'b0, ser_fast}, {7'b0, exp_b[7]});
        fall_phase();
        check("R3 slow after fall", {7'b0, ser_slow}, {7'b0, exp_b[7]});
        check("R4 transparent follow", par_data, exp_b);

        // R4 hold: strobe low, new word shifted, old word retained
        strobe_in = 1'b0;
        tick(3);
        shift_byte(8'h5A);
        check("R4 R5 hold old word", par_data, exp_b);
        exp_b = 8'h5A;
        strobe_in = 1'b1;
        tick(3);
        check("R4 new word after strobe", par_data, exp_b);

        // R8: latency from raw shift clock to state change
        data_in = 1'b0;
        tick(3);
        sclk_in = 1'b1;
        tick(2);
        check("R8 no change after two edges", {7'b0, ser_fast}, 8'h00);
        tick(1);
        check("R8 change after third edge", {7'b0, ser_fast}, 8'h01);
        exp_b = {exp_b[6:0], 1'b0};
        tick(2);
        fall_phase();

        // R6, R7: enable low gates only the drive enables
        oe_in = 1'b0;
        tick(3);
        check("R6 enable low", par_en, '0);
        rise_phase(1'b1);
        fall_phase();
        exp_b = {exp_b[6:0], 1'b1};
        check("R7 shift continues while disabled", par_data, exp_b);
        check("R6 serial not gated", {7'b0, ser_fast}, {7'b0, exp_b[7]});
        check("R6 enable still low", par_en, '0);
        tick(2);
        finish_run();
    end

endmodule